// File: doc/BRIEF.md
# Glitch-Filtered Reset Conditioner

This block sits between an external active-high reset pin and the logic of one clock domain. A long board trace can pick up narrow spurious pulses, so the pin is first qualified: it only counts as a reset once it has stayed high for a window of clock cycles. The window is set by `FILTER_CYCLES`, which defaults to 20 cycles, about 100 ns at a 200 MHz clock. The filtered level goes low again the moment the pin goes low, with no window on release. The block forms that level as the AND of the raw pin with a clock-counted, delayed view of the same pin.

The filtered level drives a two-stage reset synchroniser. Reset reaches the domain at once, without waiting for a clock edge, and is released only on a clock edge. Release also waits for the clock-generator lock flag. Losing lock puts the domain back into reset after two edges. The block has no reset input of its own: its registers take initial values that leave the domain in reset at power-up.

Top module: `rst_conditioner`

## Requirements
- R1: At power-up, with the pin low and lock low, `rst_n_o` is 0 and `rst_filt_o` is 0.
- R2: With `FILTER_CYCLES` = N, the pin is sampled through two flip-flops and counted. If the pin is high at N+2 consecutive rising edges, `rst_filt_o` becomes 1 just after the (N+2)th edge.
- R3: If the pin is high for at most N+1 consecutive rising edges and then low, `rst_filt_o` never becomes 1 and `rst_n_o` does not leave its released value of 1.
- R4: `rst_filt_o` is 1 only while the pin is 1. It falls in the same instant as the pin falls, without waiting for a clock edge.
- R5: `rst_n_o` goes to 0 in the same instant that `rst_filt_o` goes to 1, not on a later clock edge.
- R6: Once `rst_filt_o` is 0 and the lock flag is 1, `rst_n_o` becomes 1 just after the second rising edge, and not after the first.
- R7: While the lock flag is 0, `rst_n_o` stays 0 whatever the pin does.
- R8: If the lock flag falls while `rst_n_o` is 1, `rst_n_o` stays 1 after the first rising edge and is 0 after the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock of the destination domain |
| rst_pin_i | input | 1 | Raw external reset, active high, asynchronous |
| clk_lock_i | input | 1 | Lock flag of the clock generator, 1 when locked |
| rst_filt_o | output | 1 | Qualified reset level, active high |
| rst_n_o | output | 1 | Reset for the domain, active low, released in step with `clk` |

## Verification
Some rules are checked at every clock edge: the filtered level is never high without the pin, the domain reset is active whenever the filtered level is high, a low lock flag forces reset two edges later, and every release is preceded by two edges of lock with no filtered reset. Other behaviour only the bench scenarios can show. These are the exact qualification edge, the rejection of pulses one and two edges short of it, the sub-cycle fall of the filtered level when the pin drops, and the absence of an extra cycle between qualification and reset entry.

// File: rtl/rstcond_pkg.sv
package rstcond_pkg;

  // Nominal clock and target rejection window, in picoseconds.
  localparam int unsigned NOMINAL_PERIOD_PS = 5000;
  localparam int unsigned TARGET_WINDOW_PS  = 100000;

  // Default qualification length in clock cycles (about 100 ns at 200 MHz).
  localparam int unsigned DEFAULT_FILTER_CYCLES = TARGET_WINDOW_PS / NOMINAL_PERIOD_PS;

  // Width of a counter that must hold 0..limit, never below one bit.
  function automatic int unsigned ctr_width(input int unsigned limit);
    int unsigned w;
    w = $clog2(limit + 1);
    return (w < 1) ? 1 : w;
  endfunction

endpackage

// File: rtl/rstcond_sync.sv
// Plain multi-flop synchroniser with a power-up value instead of a reset.
module rstcond_sync #(
  parameter int unsigned STAGES = 2,
  parameter bit          INIT   = 1'b1
) (
  input  logic clk,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] sr = {STAGES{INIT}};

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        sr <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        sr <= {sr[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sr[STAGES-1];

endmodule

// File: rtl/rstcond_qual.sv
// Qualification counter: saturates after FILTER_CYCLES samples of a high
// synchronised level; the result is ANDed with the raw pin so release is
// immediate (R2, R4).
module rstcond_qual
  import rstcond_pkg::*;
#(
  parameter int unsigned FILTER_CYCLES = DEFAULT_FILTER_CYCLES
) (
  input  logic clk,
  input  logic level_i,
  input  logic raw_i,
  output logic filt_o
);

  localparam int unsigned CW = ctr_width(FILTER_CYCLES);
  localparam logic [CW-1:0] LIMIT = CW'(FILTER_CYCLES);

  // Starts saturated so that a pin held high at power-up is honoured at once.
  logic [CW-1:0] run_q = LIMIT;
  logic          full;

  assign full = (run_q == LIMIT);

  always_ff @(posedge clk) begin
    if (!level_i) begin
      run_q <= '0;
    end else if (!full) begin
      run_q <= run_q + 1'b1;
    end
  end

  assign filt_o = full & raw_i;

endmodule

// File: rtl/rstcond_release.sv
// Reset bridge: enters reset asynchronously, leaves it through a flop chain
// that shifts in the lock flag (R5, R6, R7, R8).
module rstcond_release #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_i,
  input  logic lock_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q = '0;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or posedge arst_i) begin
        if (arst_i) chain_q <= '0;
        else        chain_q <= lock_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk or posedge arst_i) begin
        if (arst_i) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], lock_i};
      end
    end
  endgenerate

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/rst_conditioner.sv
module rst_conditioner
  import rstcond_pkg::*;
#(
  parameter int unsigned FILTER_CYCLES  = DEFAULT_FILTER_CYCLES,
  parameter int unsigned PIN_SYNC_DEPTH = 2,
  parameter int unsigned RELEASE_DEPTH  = 2
) (
  input  logic clk,
  input  logic rst_pin_i,
  input  logic clk_lock_i,
  output logic rst_filt_o,
  output logic rst_n_o
);

  logic pin_sync;

  rstcond_sync #(
    .STAGES (PIN_SYNC_DEPTH),
    .INIT   (1'b1)
  ) u_pin_sync (
    .clk (clk),
    .d_i (rst_pin_i),
    .q_o (pin_sync)
  );

  rstcond_qual #(
    .FILTER_CYCLES (FILTER_CYCLES)
  ) u_qual (
    .clk     (clk),
    .level_i (pin_sync),
    .raw_i   (rst_pin_i),
    .filt_o  (rst_filt_o)
  );

  rstcond_release #(
    .STAGES (RELEASE_DEPTH)
  ) u_release (
    .clk     (clk),
    .arst_i  (rst_filt_o),
    .lock_i  (clk_lock_i),
    .rst_n_o (rst_n_o)
  );

endmodule

// File: rtl/rst_conditioner_chk.sv
module rst_conditioner_chk (
  input logic clk,
  input logic pin,
  input logic lock,
  input logic filt,
  input logic rst_n
);

  // Counts the first edges so that no property looks before time zero.
  logic [1:0] warm = '0;
  logic       live;

  always_ff @(posedge clk) begin
    if (warm != 2'd3) warm <= warm + 2'd1;
  end

  assign live = (warm == 2'd3);

  // R4
  filt_needs_pin_chk: assert property (@(posedge clk) disable iff (!live)
    filt |-> pin);

  // R5
  filt_forces_reset_chk: assert property (@(posedge clk) disable iff (!live)
    filt |-> !rst_n);

  // R7
  unlocked_holds_reset_chk: assert property (@(posedge clk) disable iff (!live)
    !lock |-> ##2 !rst_n);

  // R6
  release_after_two_edges_chk: assert property (@(posedge clk) disable iff (!live)
    $rose(rst_n) |-> ($past(lock, 2) && !$past(filt) && !$past(filt, 2)));

endmodule

bind rst_conditioner rst_conditioner_chk u_chk (
  .clk   (clk),
  .pin   (rst_pin_i),
  .lock  (clk_lock_i),
  .filt  (rst_filt_o),
  .rst_n (rst_n_o)
);

// File: tb/test_rst_conditioner.sv
`timescale 1ns/1ps
module test_rst_conditioner;

  localparam int unsigned N = 20;

  logic clk = 1'b0;
  logic pin = 1'b0;
  logic lock = 1'b0;
  logic filt;
  logic rst_n;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  rst_conditioner #(.FILTER_CYCLES(N)) i_rst_conditioner (
    .clk        (clk),
    .rst_pin_i  (pin),
    .clk_lock_i (lock),
    .rst_filt_o (filt),
    .rst_n_o    (rst_n)
  );

  task automatic check(input bit actual, input bit expected, input string req, input string what);
    n_checks++;
    if (actual !== expected) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, actual, expected, $time);
    end
  endtask

  task automatic edge_sample();
    @(posedge clk);
    #1;
  endtask

  task automatic at_negedge();
    @(negedge clk);
  endtask

  task automatic release_two_edges(input string req);
    edge_sample();
    check(rst_n, 1'b0, req, "rst_n after first edge");
    edge_sample();
    check(rst_n, 1'b1, req, "rst_n after second edge");
  endtask

  // R1, R7, R6: power-up state, hold while unlocked, then release.
  task automatic t_power_up();
    #1;
    check(rst_n, 1'b0, "R1", "rst_n at power-up");
    check(filt, 1'b0, "R1", "filt at power-up");
    for (int k = 0; k < 10; k++) edge_sample();
    check(rst_n, 1'b0, "R7", "rst_n with lock low");
    at_negedge();
    lock = 1'b1;
    release_two_edges("R6");
  endtask

  // R3: a pulse spanning w edges must leave everything untouched.
  task automatic t_short_pulse(input int w);
    bit seen_filt = 1'b0;
    bit seen_rst  = 1'b0;
    at_negedge();
    pin = 1'b1;
    for (int k = 0; k < w; k++) begin
      edge_sample();
      seen_filt |= filt;
      seen_rst  |= !rst_n;
    end
    at_negedge();
    pin = 1'b0;
    for (int k = 0; k < 6; k++) begin
      edge_sample();
      seen_filt |= filt;
      seen_rst  |= !rst_n;
    end
    check(seen_filt, 1'b0, "R3", $sformatf("filt seen for %0d-edge pulse", w));
    check(seen_rst, 1'b0, "R3", $sformatf("rst_n low for %0d-edge pulse", w));
  endtask

  // R2, R5, R4, R6: qualifying pulse of N+2+extra edges.
  task automatic t_qualify(input int extra);
    bit early = 1'b0;
    at_negedge();
    pin = 1'b1;
    for (int k = 0; k < N + 1; k++) begin
      edge_sample();
      early |= filt;
    end
    check(early, 1'b0, "R2", "filt before edge N+2");
    edge_sample();
    check(filt, 1'b1, "R2", "filt after edge N+2");
    check(rst_n, 1'b0, "R5", "rst_n in same cycle as filt");
    for (int k = 0; k < extra; k++) edge_sample();
    check(filt, 1'b1, "R2", "filt held during long pulse");
    at_negedge();
    pin = 1'b0;
    #1;
    check(filt, 1'b0, "R4", "filt drops before next edge");
    check(rst_n, 1'b0, "R4", "rst_n still low before next edge");
    release_two_edges("R6");
  endtask

  // R8, R7, R6: lock loss and recovery.
  task automatic t_lock();
    at_negedge();
    lock = 1'b0;
    edge_sample();
    check(rst_n, 1'b1, "R8", "rst_n after first edge of lock loss");
    edge_sample();
    check(rst_n, 1'b0, "R8", "rst_n after second edge of lock loss");
    at_negedge();
    pin = 1'b1;
    for (int k = 0; k < N + 6; k++) edge_sample();
    at_negedge();
    pin = 1'b0;
    for (int k = 0; k < 12; k++) edge_sample();
    check(rst_n, 1'b0, "R7", "rst_n held while unlocked after pin release");
    at_negedge();
    lock = 1'b1;
    release_two_edges("R6");
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    t_power_up();
    t_short_pulse(N - 1);
    t_short_pulse(N);
    t_short_pulse(N + 1);
    t_qualify(0);
    t_qualify(30);
    t_lock();
    t_short_pulse(3);
    done = 1'b1;
    report();
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished at %0t", $time);
      report();
    end
  end

endmodule